// File: doc/BRIEF.md
# Hash Core Idle and Thermal Supervisor

This block sits beside a pair of hash cores and decides whether they may run. It watches two things: a single-cycle pulse for every byte the host link receives, and a stream of digitized temperature readings. When the host link stays quiet for a long, parameter-set number of hash-clock cycles, the cores are idled to save power. The next received byte wakes them. At the default setting this is three minutes at 200 MHz, which is 36,000,000,000 cycles and needs a 36-bit counter.

A valid temperature reading above a host-programmed limit shuts all cores down. This shutdown is latched. Link traffic cannot undo it. It is released only after two things have happened in order: a later reading has dropped a hysteresis margin below the limit, and the host has then pulsed a clear input. A status word gives the mode and the most recent temperature reading, so the host can read both over its register bus.

The control is a four-state machine:
- `ST_ACTIVE`: cores running, inactivity counter counting.
- `ST_IDLE`: cores stopped after the timeout.
- `ST_TRIPPED`: over-temperature latched, not yet cool.
- `ST_COOLED`: latched, but a cool reading has been seen, so a clear is accepted.

The transitions are:
- timeout: ACTIVE to IDLE.
- wake: IDLE to ACTIVE on a byte pulse.
- trip: any state to TRIPPED on an over-limit reading.
- cooled: TRIPPED to COOLED on a cool reading.
- rewarm: COOLED to TRIPPED on a valid reading that is not cool.
- release: COOLED to ACTIVE on a host clear.

Top module: `hashcore_governor`

## Requirements
- R1: After reset, every bit of `core_run` is 1, the status word shows running only, and the temperature field is 0.
- R2: With no byte pulse, `core_run` drops to all zeros and the idle status bit rises on the IDLE_CYCLES-th rising edge after reset is released.
- R3: A byte pulse sampled at an edge while running restarts the count. This includes a pulse on the very cycle the count would expire. The cores then idle on the IDLE_CYCLES-th edge after that edge.
- R4: While idle, a byte pulse sets all of `core_run` to 1 at the next edge, with the count restarted from zero.
- R5: A reading with `temp_valid` high and `temp_sample` strictly greater than `temp_limit` forces the thermal state at the next edge from any state, with `core_run` all zeros. A reading equal to the limit does not trip.
- R6: `temp_sample` is ignored while `temp_valid` is low. It changes neither the mode nor the temperature field.
- R7: The thermal state is latched. Byte pulses never re-enable the cores while it is set. A clear pulse is ignored until a valid reading with `temp_sample + HYST_MARGIN < temp_limit` has arrived.
- R8: In the cooled condition, a clear pulse returns the cores to running at the next edge, with the count from zero. A valid reading that is not cool, arriving before the clear, re-arms the need for a new cool reading. A not-cool reading takes priority over a clear in the same cycle.
- R9: Status layout:
  - bit 0: running
  - bit 1: idle
  - bit 2: thermal shutdown
  - bit 3: zero
  - bits [TEMP_W+3:4]: the last valid reading

  Exactly one of bits 0 to 2 is set.
- R10: An over-limit reading beats a byte pulse in the same cycle.
- R11: All bits of `core_run` carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Hash-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte_pulse | input | 1 | One-cycle pulse per received link byte |
| temp_sample | input | TEMP_W | Digitized temperature reading |
| temp_valid | input | 1 | Reading strobe, high for one cycle per sample |
| temp_limit | input | TEMP_W | Programmed operating limit |
| thermal_clear | input | 1 | Host clear request pulse |
| core_run | output | NUM_CORES | Per-core run enable |
| status | output | TEMP_W+4 | Mode bits and last temperature reading |

## Verification
The bench builds the block with IDLE_CYCLES set to 40, HYST_MARGIN at 8, two cores and a 12-bit temperature. The short timeout makes it possible to check exact edges: the expiry edge, a byte pulse landing on the expiry cycle, and the restart after a wake or a release. The 8-count margin puts the cool boundary at 1991 against a limit of 2000. Readings of 1991, 1992, 2000 and 2001 probe both sides of both thresholds.

// File: rtl/hashcore_governor_pkg.sv
package hashcore_governor_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_IDLE    = 2'd1,
        ST_TRIPPED = 2'd2,
        ST_COOLED  = 2'd3
    } gov_state_t;

    localparam int STAT_RUN_BIT   = 0;
    localparam int STAT_IDLE_BIT  = 1;
    localparam int STAT_THERM_BIT = 2;
    localparam int STAT_TEMP_LSB  = 4;

endpackage

// File: rtl/gov_idle_timer.sv
module gov_idle_timer #(
    parameter logic [63:0] IDLE_CYCLES = 64'd36_000_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic restart,
    output logic expired
);
    localparam int CNT_W = $clog2(IDLE_CYCLES);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(IDLE_CYCLES - 64'd1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !count_en) begin
            cnt <= '0;
        end else if (cnt != TERM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = count_en && (cnt == TERM);

endmodule

// File: rtl/gov_thermal_monitor.sv
module gov_thermal_monitor #(
    parameter int TEMP_W      = 12,
    parameter int HYST_MARGIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] sample,
    input  logic              valid,
    input  logic [TEMP_W-1:0] limit,
    output logic              hot_evt,
    output logic              cool_evt,
    output logic              warm_evt,
    output logic [TEMP_W-1:0] last_sample
);
    localparam int EXT_W = TEMP_W + 1;
    localparam logic [EXT_W-1:0] HYST_EXT = EXT_W'(HYST_MARGIN);

    logic [EXT_W-1:0] sample_plus_margin;
    logic             below_band;

    assign sample_plus_margin = {1'b0, sample} + HYST_EXT;
    assign below_band         = sample_plus_margin < {1'b0, limit};

    always_comb begin
        hot_evt  = valid && (sample > limit);
        cool_evt = valid && below_band;
        warm_evt = valid && !below_band;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_sample <= '0;
        end else if (valid) begin
            last_sample <= sample;
        end
    end

endmodule

// File: rtl/gov_fsm.sv
module gov_fsm
    import hashcore_governor_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_evt,
    input  logic       hot_evt,
    input  logic       cool_evt,
    input  logic       warm_evt,
    input  logic       clear_req,
    input  logic       expired,
    output gov_state_t state,
    output logic       run_all,
    output logic       idle_flag,
    output logic       therm_flag
);
    gov_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ACTIVE: begin
                if (hot_evt)                  state_nxt = ST_TRIPPED;
                else if (!rx_evt && expired)  state_nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (hot_evt)                  state_nxt = ST_TRIPPED;
                else if (rx_evt)              state_nxt = ST_ACTIVE;
            end
            ST_TRIPPED: begin
                if (cool_evt)                 state_nxt = ST_COOLED;
            end
            ST_COOLED: begin
                if (hot_evt || warm_evt)      state_nxt = ST_TRIPPED;
                else if (clear_req)           state_nxt = ST_ACTIVE;
            end
            default:                          state_nxt = ST_TRIPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ACTIVE;
        else        state <= state_nxt;
    end

    always_comb begin
        run_all    = 1'b0;
        idle_flag  = 1'b0;
        therm_flag = 1'b0;
        unique case (state)
            ST_ACTIVE:  run_all    = 1'b1;
            ST_IDLE:    idle_flag  = 1'b1;
            ST_TRIPPED: therm_flag = 1'b1;
            ST_COOLED:  therm_flag = 1'b1;
            default:    therm_flag = 1'b1;
        endcase
    end

endmodule

// File: rtl/hashcore_governor.sv
module hashcore_governor
    import hashcore_governor_pkg::*;
#(
    parameter int          NUM_CORES   = 2,
    parameter int          TEMP_W      = 12,
    parameter int          HYST_MARGIN = 8,
    parameter logic [63:0] IDLE_CYCLES = 64'd36_000_000_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_byte_pulse,
    input  logic [TEMP_W-1:0]    temp_sample,
    input  logic                 temp_valid,
    input  logic [TEMP_W-1:0]    temp_limit,
    input  logic                 thermal_clear,
    output logic [NUM_CORES-1:0] core_run,
    output logic [TEMP_W+3:0]    status
);
    logic              hot_evt, cool_evt, warm_evt, expired;
    logic [TEMP_W-1:0] last_sample;
    gov_state_t        state;
    logic              run_all, idle_flag, therm_flag;

    gov_thermal_monitor #(
        .TEMP_W     (TEMP_W),
        .HYST_MARGIN(HYST_MARGIN)
    ) u_therm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (temp_sample),
        .valid      (temp_valid),
        .limit      (temp_limit),
        .hot_evt    (hot_evt),
        .cool_evt   (cool_evt),
        .warm_evt   (warm_evt),
        .last_sample(last_sample)
    );

    gov_idle_timer #(
        .IDLE_CYCLES(IDLE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(state == ST_ACTIVE),
        .restart (rx_byte_pulse),
        .expired (expired)
    );

    gov_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_evt    (rx_byte_pulse),
        .hot_evt   (hot_evt),
        .cool_evt  (cool_evt),
        .warm_evt  (warm_evt),
        .clear_req (thermal_clear),
        .expired   (expired),
        .state     (state),
        .run_all   (run_all),
        .idle_flag (idle_flag),
        .therm_flag(therm_flag)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_en
        assign core_run[c] = run_all;
    end

    always_comb begin
        status                               = '0;
        status[STAT_RUN_BIT]                 = run_all;
        status[STAT_IDLE_BIT]                = idle_flag;
        status[STAT_THERM_BIT]               = therm_flag;
        status[STAT_TEMP_LSB +: TEMP_W]      = last_sample;
    end

endmodule

// File: rtl/hashcore_governor_checks.sv
module hashcore_governor_checks #(
    parameter int NUM_CORES = 2,
    parameter int TEMP_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_byte_pulse,
    input logic [TEMP_W-1:0]    temp_sample,
    input logic                 temp_valid,
    input logic [TEMP_W-1:0]    temp_limit,
    input logic                 thermal_clear,
    input logic [NUM_CORES-1:0] core_run,
    input logic [TEMP_W+3:0]    status
);
    logic over;
    assign over = temp_valid && (temp_sample > temp_limit);

    p_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> (status[2] && core_run == '0));

    p_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !thermal_clear) |=> status[2]);

    p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && rx_byte_pulse && !over) |=> (&core_run));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> !$past(rx_byte_pulse));

    p_mode_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(status[2:0]) == 1) && !status[3]);

    p_temp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid |=> $stable(status[TEMP_W+3:4]));

    p_uniform_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run == '0) || (&core_run));

endmodule

bind hashcore_governor hashcore_governor_checks #(
    .NUM_CORES(NUM_CORES),
    .TEMP_W   (TEMP_W)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_byte_pulse(rx_byte_pulse),
    .temp_sample  (temp_sample),
    .temp_valid   (temp_valid),
    .temp_limit   (temp_limit),
    .thermal_clear(thermal_clear),
    .core_run     (core_run),
    .status       (status)
);

// File: tb/test_hashcore_governor.sv
module test_hashcore_governor;
    localparam int NC = 2;
    localparam int TW = 12;
    localparam int N  = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b0;
    logic [TW-1:0] ts = '0;
    logic          tv = 1'b0;
    logic [TW-1:0] tl = 12'd2000;
    logic          clr = 1'b0;
    logic [NC-1:0] core_run;
    logic [TW+3:0] status;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;
    logic [TW-1:0] last_t = '0;

    always #4 clk = ~clk;

    hashcore_governor #(
        .NUM_CORES(NC), .TEMP_W(TW), .HYST_MARGIN(8), .IDLE_CYCLES(64'd40)
    ) i_hashcore_governor (
        .clk(clk), .rst_n(rst_n), .rx_byte_pulse(rx), .temp_sample(ts),
        .temp_valid(tv), .temp_limit(tl), .thermal_clear(clr),
        .core_run(core_run), .status(status)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode: 0 running, 1 idle, 2 thermal
    task automatic check_mode(input string req, input int mode);
        logic [TW+3:0] exp_s;
        exp_s = {last_t, 1'b0, mode == 2, mode == 1, mode == 0};
        check({req, " status"}, 32'(status), 32'(exp_s));
        check({req, " core_run R11"}, 32'(core_run), (mode == 0) ? 32'h3 : 32'h0);
    endtask

    task automatic sample(input logic [TW-1:0] v);
        tv = 1'b1; ts = v; tick(); tv = 1'b0; last_t = v;
    endtask

    task automatic pulse_rx();
        rx = 1'b1; tick(); rx = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1; tick(); clr = 1'b0;
    endtask

    task automatic t_reset();
        ticks(3);
        rst_n = 1'b1;
        check_mode("R1 reset state", 0);
    endtask

    task automatic t_idle_timeout();
        ticks(N - 1);
        check_mode("R2 running one edge before timeout", 0);
        tick();
        check_mode("R2 idle at timeout", 1);
    endtask

    task automatic t_wake();
        pulse_rx();
        check_mode("R4 wake on byte", 0);
        ticks(N - 1);
        check_mode("R4 count restarted after wake", 0);
        tick();
        check_mode("R4 idle again after wake", 1);
    endtask

    task automatic t_restart();
        pulse_rx();
        ticks(20);
        pulse_rx();
        ticks(N - 1);
        check_mode("R3 restart mid-count still running", 0);
        tick();
        check_mode("R3 idle after restarted count", 1);
        pulse_rx();
        ticks(N - 1);
        pulse_rx();
        check_mode("R3 byte on expiry cycle keeps running", 0);
        ticks(N - 1);
        check_mode("R3 still running after expiry-cycle byte", 0);
        tick();
        check_mode("R3 idle after expiry-cycle restart", 1);
    endtask

    task automatic t_ignore_invalid();
        tv = 1'b0; ts = 12'd4000; tick();
        check_mode("R6 invalid reading ignored", 1);
        sample(12'd2000);
        check_mode("R5 reading equal to limit does not trip, R9 temp field", 1);
    endtask

    task automatic t_priority_latch();
        rx = 1'b1; tv = 1'b1; ts = 12'd2001; tick();
        rx = 1'b0; tv = 1'b0; last_t = 12'd2001;
        check_mode("R10 over-temp beats byte", 2);
        pulse_rx();
        check_mode("R7 byte does not re-enable", 2);
        pulse_clr();
        check_mode("R7 clear ignored before cool reading", 2);
        sample(12'd1992);
        pulse_clr();
        check_mode("R7 clear ignored at margin boundary", 2);
    endtask

    task automatic t_clear();
        sample(12'd1991);
        check_mode("R8 cooled still latched", 2);
        sample(12'd1995);
        pulse_clr();
        check_mode("R8 rewarm re-arms latch", 2);
        sample(12'd1991);
        clr = 1'b1; tv = 1'b1; ts = 12'd1993; tick();
        clr = 1'b0; tv = 1'b0; last_t = 12'd1993;
        check_mode("R8 warm reading beats clear", 2);
        sample(12'd1500);
        pulse_clr();
        check_mode("R8 release on clear", 0);
        ticks(N - 1);
        check_mode("R8 count from zero after release", 0);
        tick();
        check_mode("R8 idle after release count", 1);
        pulse_rx();
        sample(12'd2500);
        check_mode("R5 trip from running", 2);
    endtask

    initial begin
        t_reset();
        t_idle_timeout();
        t_wake();
        t_restart();
        t_ignore_invalid();
        t_priority_latch();
        t_clear();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule